// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupts

This block is a parameterised general-purpose I/O port (eight pins by default). Each pin takes one of four personalities from two mode bits: a driven output, a plain input, a level-sensitive interrupt source or an edge-sensitive interrupt source. A small register interface holds, per pin, a data bit, two mode bits and an edge flag. Every pin input passes through a two-flop synchronizer before anything looks at it.

In level mode the pin's data bit selects which level requests service. The output driver is off, so the pin is an input. A per-pin qualifier state machine has three states: `LQ_IDLE`, `LQ_ARMED` and `LQ_ACTIVE`. Its transitions are:

- *arm* (`LQ_IDLE`→`LQ_ARMED`) on the first matching synchronized sample.
- *confirm* (`LQ_ARMED`→`LQ_ACTIVE`) on a second consecutive match.
- *hold* (`LQ_ACTIVE`→`LQ_ACTIVE`) while the match lasts.
- *abort* (`LQ_ARMED`→`LQ_IDLE`) and *release* (`LQ_ACTIVE`→`LQ_IDLE`) on a mismatch.
- *disable* (any state→`LQ_IDLE`) whenever the pin leaves level mode.

In edge mode the data bit selects rising or falling. A detected edge sets a sticky flag that software clears by writing 1 to the status register. The per-pin requests drive `pin_irq`, and their OR drives `irq`.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset all pins are inputs: mode-low register (address 1) reads 0xFF, mode-high register (address 2) reads 0x00, `pin_oe`, `pin_irq` and `irq` are 0.
- R2: A pin's mode is {mode-high bit, mode-low bit}: 00 output, 01 input, 10 level interrupt, 11 edge interrupt. `pin_oe` is high only in mode 00. `pin_out` carries the data register (address 0).
- R3: Reading address 0 returns the data register bit for output pins and the synchronized pin level for all other pins. The input of an output pin is ignored.
- R4: A change on `pin_in` becomes visible on the address-0 read two clock edges later (two-flop synchronizer).
- R5: In level mode, `pin_irq` rises four edges after the pin starts matching: two synchronizer edges plus two consecutive matching samples (arm, confirm).
- R6: A level request holds while the synchronized level keeps matching, and drops three edges after the pin stops matching.
- R7: The level that requests is the pin's data bit: 0 requests on low, 1 requests on high.
- R8: In edge mode, data bit 1 selects rising edges and 0 selects falling edges. A selected edge sets the pin's flag (read at address 3) three edges after the pin changes. The flag is sticky, and the unselected edge has no effect.
- R9: Writing 1 to a bit of address 3 clears that pin's flag. Writing 0 has no effect. A clear in the same cycle as a new edge leaves the flag set.
- R10: `irq` is the OR of `pin_irq`. Pins in output or input mode never drive `pin_irq`, and leaving level mode drops the request at once.
- R11: A matching level seen for only one synchronized sample never raises a level request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 data, 1 mode low, 2 mode high, 3 edge flags |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr` (combinational) |
| pin_in | input | NPINS | Pin levels, asynchronous |
| pin_out | output | NPINS | Output drive values |
| pin_oe | output | NPINS | Output drive enables |
| pin_irq | output | NPINS | Per-pin interrupt requests |
| irq | output | 1 | Combined interrupt request |

## Verification
The properties assume that `pin_in` has settled through the synchronizer at least once after reset, and that register writes are single-cycle strobes with stable address and data. Under those assumptions they relate a level request only to matches of the synchronized sample against the data bit, and a flag drop only to an explicit clear.

The stimulus changes pins only one clock after an edge and holds them for several cycles, except in the deliberate one-sample glitch. It reconfigures modes in an order that never makes an interrupt pin sample a false edge. The set-versus-clear race is produced by timing a clear write onto the exact edge where the flag sets.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        PM_OUTPUT = 2'b00,
        PM_INPUT  = 2'b01,
        PM_LEVEL  = 2'b10,
        PM_EDGE   = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        LQ_IDLE   = 2'd0,
        LQ_ARMED  = 2'd1,
        LQ_ACTIVE = 2'd2
    } lvl_state_e;

    localparam logic [1:0] REG_DATA   = 2'd0;
    localparam logic [1:0] REG_MODE_L = 2'd1;
    localparam logic [1:0] REG_MODE_H = 2'd2;
    localparam logic [1:0] REG_FLAGS  = 2'd3;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [NPINS-1:0] bus_wdata,
    input  logic [NPINS-1:0] pin_sync,
    input  logic [NPINS-1:0] edge_flag,
    output logic [NPINS-1:0] data_q,
    output logic [NPINS-1:0] mode_lo,
    output logic [NPINS-1:0] mode_hi,
    output logic [NPINS-1:0] flag_clr,
    output logic [NPINS-1:0] bus_rdata
);
    logic [NPINS-1:0] is_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            mode_lo <= '1;
            mode_hi <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                REG_DATA:   data_q  <= bus_wdata;
                REG_MODE_L: mode_lo <= bus_wdata;
                REG_MODE_H: mode_hi <= bus_wdata;
                default:    ;
            endcase
        end
    end

    assign flag_clr = (bus_wr && bus_addr == REG_FLAGS) ? bus_wdata : '0;
    assign is_out   = ~mode_hi & ~mode_lo;

    always_comb begin
        unique case (bus_addr)
            REG_DATA:   bus_rdata = (data_q & is_out) | (pin_sync & ~is_out);
            REG_MODE_L: bus_rdata = mode_lo;
            REG_MODE_H: bus_rdata = mode_hi;
            default:    bus_rdata = edge_flag;
        endcase
    end
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
    import gpio_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode,
    input  logic      polarity,
    input  logic      smp,
    input  logic      clr,
    output logic      flag,
    output logic      irq_req
);
    lvl_state_e state_q, state_d;
    logic       match;
    logic       prev_q;
    logic       hit;

    assign match = (smp == polarity);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LQ_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: arm, confirm, hold, abort, release, disable
    always_comb begin
        state_d = LQ_IDLE;
        if (mode == PM_LEVEL) begin
            unique case (state_q)
                LQ_IDLE:   state_d = match ? LQ_ARMED  : LQ_IDLE;
                LQ_ARMED:  state_d = match ? LQ_ACTIVE : LQ_IDLE;
                LQ_ACTIVE: state_d = match ? LQ_ACTIVE : LQ_IDLE;
                default:   state_d = LQ_IDLE;
            endcase
        end
    end

    // Edge detection and sticky flag
    assign hit = (mode == PM_EDGE) &&
                 (polarity ? (smp && !prev_q) : (!smp && prev_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            flag   <= 1'b0;
        end else begin
            prev_q <= smp;
            flag   <= hit || (flag && !clr);
        end
    end

    // Outputs
    always_comb begin
        unique case (mode)
            PM_LEVEL: irq_req = (state_q == LQ_ACTIVE);
            PM_EDGE:  irq_req = flag;
            default:  irq_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_irq,
    output logic             irq
);
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] mode_lo;
    logic [NPINS-1:0] mode_hi;
    logic [NPINS-1:0] flag_clr;
    logic [NPINS-1:0] edge_flag;

    gpio_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .edge_flag (edge_flag),
        .data_q    (data_q),
        .mode_lo   (mode_lo),
        .mode_hi   (mode_hi),
        .flag_clr  (flag_clr),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_irq u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (pin_mode_e'({mode_hi[i], mode_lo[i]})),
            .polarity (data_q[i]),
            .smp      (pin_sync[i]),
            .clr      (flag_clr[i]),
            .flag     (edge_flag[i]),
            .irq_req  (pin_irq[i])
        );
    end

    assign pin_oe  = ~mode_hi & ~mode_lo;
    assign pin_out = data_q;
    assign irq     = |pin_irq;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic [NPINS-1:0] bus_wdata,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] pin_irq,
    input logic             irq,
    input logic [NPINS-1:0] mode_lo,
    input logic [NPINS-1:0] mode_hi,
    input logic [NPINS-1:0] data_q,
    input logic [NPINS-1:0] pin_sync,
    input logic [NPINS-1:0] edge_flag
);
    // R2: a driver is enabled only on pins whose mode is output
    a_r2_oe_output_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & (mode_hi | mode_lo)) == '0);

    // R10: input and output pins never request
    a_r10_no_req_outside_irq_modes: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_irq & ~mode_hi) == '0);

    // R10: combined request agrees with the per-pin requests
    a_r10_combined: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pin_irq != '0));

    for (genvar g = 0; g < NPINS; g++) begin : g_chk
        // R5, R11: a level request needs two consecutive matching samples
        a_r5_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pin_irq[g]) && mode_hi[g] && !mode_lo[g])
            |-> ($past(pin_sync[g] == data_q[g]) && $past(pin_sync[g] == data_q[g], 2)));

        // R6: a mismatch in level mode releases the request on the next edge
        a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_hi[g] && !mode_lo[g] && $past(mode_hi[g] && !mode_lo[g]) &&
             $past(pin_sync[g] != data_q[g]))
            |-> !pin_irq[g]);

        // R8, R9: a flag only drops after a write-one clear
        a_r9_flag_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(edge_flag[g])
            |-> $past(bus_wr && bus_addr == 2'd3 && bus_wdata[g]));
    end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .pin_irq   (pin_irq),
    .irq       (irq),
    .mode_lo   (mode_lo),
    .mode_hi   (mode_hi),
    .data_q    (data_q),
    .pin_sync  (pin_sync),
    .edge_flag (edge_flag)
);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;
    localparam int N = 8;
    localparam int K_PIRQ = 0, K_IRQ = 1, K_OE = 2, K_OUT = 3, K_RD = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic         bus_wr = 1'b0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe, pin_irq;
    logic         irq;

    gpio_irq_port #(.NPINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_irq(pin_irq), .irq(irq)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int           due;
        int           kind;
        logic [N-1:0] exp;
        string        req;
    } exp_t;

    exp_t sbq[$];
    exp_t it;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;
    logic [N-1:0] act;

    // Monitor: pops expectations due this cycle and compares
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            it = sbq.pop_front();
            case (it.kind)
                K_PIRQ:  act = pin_irq;
                K_IRQ:   act = {{(N-1){1'b0}}, irq};
                K_OE:    act = pin_oe;
                K_OUT:   act = pin_out;
                default: act = bus_rdata;
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                         it.req, it.kind, cyc, act, it.exp);
            end
        end
    end

    task automatic push(int kind, logic [N-1:0] e, string req);
        exp_t x;
        x.due = cyc; x.kind = kind; x.exp = e; x.req = req;
        sbq.push_back(x);
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wreg(logic [1:0] a, logic [N-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0;
    endtask

    task automatic rchk(logic [1:0] a, logic [N-1:0] e, string req);
        bus_addr = a;
        push(K_RD, e, req);
    endtask

    task automatic chk_irq(logic [N-1:0] e, string req);
        push(K_PIRQ, e, req);
        push(K_IRQ, {{(N-1){1'b0}}, |e}, req);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        push(K_OE, 8'h00, "R1"); chk_irq(8'h00, "R1");
        rchk(2'd1, 8'hFF, "R1"); step(1);
        rchk(2'd2, 8'h00, "R1"); step(1);
        rchk(2'd0, 8'h00, "R1"); step(1);

        // R2 outputs on pins 0..3
        wreg(2'd1, 8'hF0);
        wreg(2'd0, 8'hA5);
        push(K_OE, 8'h0F, "R2"); push(K_OUT, 8'hA5, "R2");
        // R3 output pins ignore their inputs
        pin_in = 8'hCA; step(3);
        rchk(2'd0, 8'hC5, "R3"); step(1);
        // R4 two-edge synchronizer latency
        pin_in = 8'h0A;
        rchk(2'd0, 8'hC5, "R4"); step(1);
        rchk(2'd0, 8'hC5, "R4"); step(1);
        rchk(2'd0, 8'h05, "R4"); step(1);

        // R5/R7 level-low on pin 4
        pin_in = 8'h1A; step(3);
        wreg(2'd1, 8'hE0);
        wreg(2'd2, 8'h10);
        push(K_OE, 8'h0F, "R2"); chk_irq(8'h00, "R5");
        pin_in = 8'h0A;
        step(3); chk_irq(8'h00, "R5");
        step(1); chk_irq(8'h10, "R5");
        step(2); chk_irq(8'h10, "R6");
        pin_in = 8'h1A;
        step(2); chk_irq(8'h10, "R6");
        step(1); chk_irq(8'h00, "R6");

        // R11 one-sample glitch
        step(2);
        pin_in = 8'h0A; step(1); pin_in = 8'h1A;
        step(2); chk_irq(8'h00, "R11");
        step(1); chk_irq(8'h00, "R11");
        step(1); chk_irq(8'h00, "R11");

        // R7 level-high via data bit
        wreg(2'd0, 8'hB5);
        chk_irq(8'h00, "R7"); push(K_OUT, 8'hB5, "R2");
        step(1); chk_irq(8'h00, "R7");
        step(1); chk_irq(8'h10, "R7");

        // R10 leaving level mode drops the request
        wreg(2'd1, 8'hF0); chk_irq(8'h00, "R10");
        wreg(2'd2, 8'h00); chk_irq(8'h00, "R10");
        rchk(2'd0, 8'h15, "R3"); step(1);

        // R8 rising edge on pin 5
        wreg(2'd2, 8'h20);
        chk_irq(8'h00, "R8");
        pin_in = 8'h3A;
        step(2); chk_irq(8'h00, "R8");
        step(1); chk_irq(8'h20, "R8");
        pin_in = 8'h1A;
        step(4); chk_irq(8'h20, "R8");
        rchk(2'd3, 8'h20, "R8"); step(1);

        // R9 write-one-to-clear
        wreg(2'd3, 8'h00); chk_irq(8'h20, "R9");
        wreg(2'd3, 8'hDF); chk_irq(8'h20, "R9");
        wreg(2'd3, 8'h20); chk_irq(8'h00, "R9");
        rchk(2'd3, 8'h00, "R9"); step(1);

        // R8 falling edge selected, rising ignored
        wreg(2'd0, 8'h95);
        pin_in = 8'h3A;
        step(4); chk_irq(8'h00, "R8");
        pin_in = 8'h1A;
        step(2); chk_irq(8'h00, "R8");
        step(1); chk_irq(8'h20, "R8");

        // R9 set wins over simultaneous clear
        wreg(2'd3, 8'h20); chk_irq(8'h00, "R9");
        pin_in = 8'h3A;
        step(4); chk_irq(8'h00, "R9");
        pin_in = 8'h1A;
        step(2);
        wreg(2'd3, 8'h20); chk_irq(8'h20, "R9");

        // R10 two sources combined: pin 6 level-high plus pin 5 flag
        wreg(2'd0, 8'hD5);
        wreg(2'd2, 8'h60);
        wreg(2'd1, 8'hB0);
        chk_irq(8'h20, "R10");
        pin_in = 8'h5A;
        step(3); chk_irq(8'h20, "R10");
        step(1); chk_irq(8'h60, "R10");
        push(K_OE, 8'h0F, "R2");

        step(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule